// File: doc/BRIEF.md
# I2C Receive Acknowledge and Clock-Stretch Controller

This block handles the receive side of one I2C byte transfer. It runs on a fast system clock and watches SCL and SDA levels that have already been synchronised and filtered. On each SCL rising edge it shifts in one data bit, most significant bit first. In the acknowledge slot that follows the data bits it pulls SDA low for an ACK, or leaves SDA released for a NACK. It samples the level that SDA has on the acknowledge clock and keeps that level. Start and stop detection, addressing, transmit-side shifting and clock generation are handled elsewhere. A one-cycle start pulse and a receive-mode level come into the block from outside.

Completed bytes leave through a valid/ready stream port. `rx_valid` rises when a byte is ready, and `rx_data` then holds steady until the consumer accepts it by asserting `rx_ready` while `rx_valid` is high. A handshake is the read of the received byte, and it clears `rx_valid`. If the consumer does not accept a byte before the next one completes, the new byte replaces the old one. The wait mode exists to stop that from happening. Two clock-stretch mechanisms pull SCL low, each under its own mode bit:
- The early-flag hold starts before the acknowledge clock and is released by a write to the acknowledge value.
- The wait hold starts between bytes and is released by the stream handshake.

The acknowledge value is protected by an unlock bit. The value can change only when the unlock bit was already set before the write.

Top module: `i2c_rx_ack_stretch`

## Requirements
- R1: Data bits are taken on SCL rising edges, most significant bit first. The byte presented on `rx_data` equals the first eight sampled SDA levels, with the first one at bit 7.
- R2: With `cfg_early_sel`=0, `rx_valid` rises one cycle after the ninth SCL rising edge is seen. No SCL hold is applied after the eighth clock.
- R3: With `cfg_early_sel`=1, `rx_valid` rises one cycle after the eighth SCL rising edge is seen. `scl_pull` goes high one cycle after the eighth SCL falling edge is seen.
- R4: The hold started after the eighth clock stays in place until an accepted acknowledge write. An accepted write is `cfg_wr` while `ack_unlock` is already 1. A write made while the unlock bit is 0 does not release it.
- R5: With `cfg_wait_en`=1, if a byte is still unread at the ninth SCL falling edge, `scl_pull` goes high and stays high until the byte is read through the stream handshake.
- R6: With `cfg_wait_en`=0, SCL is never held between the ninth clock and the first clock of the next byte.
- R7: A write to `cfg_wr` always loads `ack_unlock` from `cfg_ack_unlock`. The write loads `ack_val` from `cfg_ack_val` only if `ack_unlock` was 1 before that write. A single write that sets both bits leaves `ack_val` unchanged.
- R8: In receive mode, `sda_pull` is 1 from one cycle after the eighth SCL falling edge until one cycle after the ninth SCL falling edge, but only when `ack_val`=0 (ACK). When `ack_val`=1 (NACK), `sda_pull` stays 0.
- R9: `ack_rcvd` holds the SDA level sampled on the ninth SCL rising edge. A value of 0 means ACK and 1 means NACK.
- R10: With `rx_mode`=0, the wait and early-flag bits have no effect. The block raises no `rx_valid`, applies no SCL hold and does not drive SDA.
- R11: While `rx_valid`=1 and `rx_ready`=0, and no new byte completes, `rx_valid` stays 1 and `rx_data` stays unchanged. A handshake clears `rx_valid` one cycle later.
- R12: `start_pulse` resets the bit count to zero and releases both SCL holds and the SDA drive.
- R13: While `rst_n`=0, every output is 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | 1 = receive mode |
| start_pulse | input | 1 | One-cycle pulse on a start condition |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| scl_pull | output | 1 | 1 = pull SCL low |
| sda_pull | output | 1 | 1 = pull SDA low |
| cfg_wr | input | 1 | Control write strobe |
| cfg_ack_val | input | 1 | Written acknowledge value (0 ACK, 1 NACK) |
| cfg_ack_unlock | input | 1 | Written acknowledge unlock bit |
| cfg_wait_en | input | 1 | Written wait-mode bit |
| cfg_early_sel | input | 1 | Written early-flag select bit |
| ack_val | output | 1 | Current acknowledge value |
| ack_unlock | output | 1 | Current unlock bit |
| ack_rcvd | output | 1 | Sampled ninth-bit level |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer accepts the byte |
| rx_data | output | 8 | Received byte |

## Verification
The assertions assume the following about the inputs:
- `scl_in` and `sda_in` are already synchronised.
- Each SCL level lasts at least one clock cycle.
- SDA changes only while SCL is low.
- `start_pulse` is a single-cycle pulse.

The stimulus meets these rules by design. The emulated master changes SDA only during the SCL low phase and holds each SCL phase for several cycles. It waits while the line is stretched, because the SCL and SDA the block sees are the master's levels ANDed with the block's own pull-low outputs, delayed by one register. A bench-side software agent performs the acknowledge writes and the byte reads that release the holds, after a fixed delay.

// File: rtl/i2c_rxack_pkg.sv
package i2c_rxack_pkg;
  typedef struct packed {
    logic ack_val;
    logic ack_unlock;
    logic wait_en;
    logic early_sel;
  } ack_cfg_t;
endpackage

// File: rtl/i2c_rxack_edge.sv
module i2c_rxack_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q;

  // Idle bus is high; resetting to 1 avoids a false rise after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_in;
  end

  assign scl_rise = scl_in & ~scl_q;
  assign scl_fall = ~scl_in & scl_q;
endmodule

// File: rtl/i2c_rxack_shifter.sv
module i2c_rxack_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  output logic [DATA_W-1:0] shift_q,
  output logic [DATA_W-1:0] shift_next,
  output logic              last_data_rise,
  output logic              ack_rise,
  output logic              ack_slot_open,
  output logic              ack_slot_close,
  output logic              ack_rcvd
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] DONE_IDX = CNT_W'(DATA_W + 1);

  logic [CNT_W-1:0] bit_cnt;

  assign shift_next     = {shift_q[DATA_W-2:0], sda_in};
  assign last_data_rise = scl_rise & (bit_cnt == LAST_IDX) & ~start_pulse;
  assign ack_rise       = scl_rise & (bit_cnt == ACK_IDX)  & ~start_pulse;
  assign ack_slot_open  = scl_fall & (bit_cnt == ACK_IDX)  & ~start_pulse;
  assign ack_slot_close = scl_fall & (bit_cnt == DONE_IDX) & ~start_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shift_q  <= '0;
      ack_rcvd <= 1'b0;
    end else if (start_pulse) begin
      bit_cnt <= '0;
    end else begin
      if (scl_rise) begin
        if (bit_cnt < ACK_IDX) shift_q <= shift_next;
        if (bit_cnt == ACK_IDX) ack_rcvd <= sda_in;
        if (bit_cnt < DONE_IDX) bit_cnt <= bit_cnt + CNT_W'(1);
      end
      if (scl_fall && bit_cnt == DONE_IDX) bit_cnt <= '0;
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= DONE_IDX);

  p_shift_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !start_pulse && bit_cnt < ACK_IDX) |=> shift_q[0] == $past(sda_in));

  p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> bit_cnt == '0);
endmodule

// File: rtl/i2c_rxack_regs.sv
module i2c_rxack_regs
  import i2c_rxack_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_wr,
  input  ack_cfg_t cfg_wdata,
  output ack_cfg_t cfg_q,
  output logic     ack_write_ok
);
  // The acknowledge value is accepted only when unlocked before this write.
  assign ack_write_ok = cfg_wr & cfg_q.ack_unlock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q.ack_unlock <= cfg_wdata.ack_unlock;
      cfg_q.wait_en    <= cfg_wdata.wait_en;
      cfg_q.early_sel  <= cfg_wdata.early_sel;
      if (cfg_q.ack_unlock) cfg_q.ack_val <= cfg_wdata.ack_val;
    end
  end

  p_ack_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_q.ack_unlock) |=> $stable(cfg_q.ack_val));

  p_unlock_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q.ack_unlock == $past(cfg_wdata.ack_unlock));
endmodule

// File: rtl/i2c_rxack_stretch.sv
module i2c_rxack_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic rx_mode,
  input  logic early_sel,
  input  logic wait_en,
  input  logic ack_val,
  input  logic ack_slot_open,
  input  logic ack_slot_close,
  input  logic ack_write_ok,
  input  logic data_read,
  input  logic flag_pending,
  output logic scl_pull,
  output logic sda_pull
);
  logic hold_early;
  logic hold_wait;
  logic ack_drv;

  always_ff @(posedge clk) begin
    if (!rst_n || start_pulse) begin
      hold_early <= 1'b0;
      hold_wait  <= 1'b0;
      ack_drv    <= 1'b0;
    end else begin
      if (ack_slot_open) begin
        ack_drv <= rx_mode;
        if (rx_mode && early_sel) hold_early <= 1'b1;
      end
      if (ack_slot_close) begin
        ack_drv <= 1'b0;
        if (rx_mode && wait_en && flag_pending && !data_read) hold_wait <= 1'b1;
      end
      if (ack_write_ok) hold_early <= 1'b0;
      if (data_read)    hold_wait  <= 1'b0;
    end
  end

  assign scl_pull = hold_early | hold_wait;
  assign sda_pull = ack_drv & ~ack_val;

  p_early_hold_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_early && !ack_write_ok && !start_pulse) |=> hold_early);

  p_wait_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wait && !data_read && !start_pulse) |=> hold_wait);

  p_tx_no_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && !scl_pull) |=> !scl_pull);

  p_start_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !scl_pull && !sda_pull);
endmodule

// File: rtl/i2c_rx_ack_stretch.sv
module i2c_rx_ack_stretch
  import i2c_rxack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              start_pulse,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              cfg_wr,
  input  logic              cfg_ack_val,
  input  logic              cfg_ack_unlock,
  input  logic              cfg_wait_en,
  input  logic              cfg_early_sel,
  output logic              ack_val,
  output logic              ack_unlock,
  output logic              ack_rcvd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data
);
  logic              scl_rise, scl_fall;
  logic [DATA_W-1:0] shift_q, shift_next;
  logic              last_data_rise, ack_rise, ack_slot_open, ack_slot_close;
  logic              ack_write_ok, data_read, byte_set;
  ack_cfg_t          cfg_wdata, cfg_q;

  assign cfg_wdata.ack_val    = cfg_ack_val;
  assign cfg_wdata.ack_unlock = cfg_ack_unlock;
  assign cfg_wdata.wait_en    = cfg_wait_en;
  assign cfg_wdata.early_sel  = cfg_early_sel;

  i2c_rxack_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_rxack_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .shift_q(shift_q), .shift_next(shift_next),
    .last_data_rise(last_data_rise), .ack_rise(ack_rise),
    .ack_slot_open(ack_slot_open), .ack_slot_close(ack_slot_close),
    .ack_rcvd(ack_rcvd)
  );

  i2c_rxack_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .ack_write_ok(ack_write_ok)
  );

  assign data_read = rx_valid & rx_ready;

  i2c_rxack_stretch u_stretch (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .rx_mode(rx_mode),
    .early_sel(cfg_q.early_sel), .wait_en(cfg_q.wait_en), .ack_val(cfg_q.ack_val),
    .ack_slot_open(ack_slot_open), .ack_slot_close(ack_slot_close),
    .ack_write_ok(ack_write_ok), .data_read(data_read), .flag_pending(rx_valid),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  // Byte-ready point: eighth rise (early) or ninth rise (late), receive mode only.
  assign byte_set = rx_mode & (cfg_q.early_sel ? last_data_rise : ack_rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (byte_set) begin
      rx_valid <= 1'b1;
      rx_data  <= cfg_q.early_sel ? shift_next : shift_q;
    end else if (data_read) begin
      rx_valid <= 1'b0;
    end
  end

  assign ack_val    = cfg_q.ack_val;
  assign ack_unlock = cfg_q.ack_unlock;

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !byte_set) |=> rx_valid && $stable(rx_data));

  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !byte_set) |=> !rx_valid);

  p_tx_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && !rx_valid) |=> !rx_valid);
endmodule

// File: tb/i2c_rx_ack_stretch_tb_top.sv
module i2c_rx_ack_stretch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_mode = 1'b1;
  logic       start_pulse = 1'b0;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       cfg_wr = 1'b0;
  logic       cfg_ack_val = 1'b0;
  logic       cfg_ack_unlock = 1'b0;
  logic       cfg_wait_en = 1'b0;
  logic       cfg_early_sel = 1'b0;
  logic       rx_ready = 1'b0;
  logic       scl_pull, sda_pull, ack_val, ack_unlock, ack_rcvd, rx_valid;
  logic [7:0] rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rx_ack_stretch dut_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .start_pulse(start_pulse),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .cfg_wr(cfg_wr), .cfg_ack_val(cfg_ack_val), .cfg_ack_unlock(cfg_ack_unlock),
    .cfg_wait_en(cfg_wait_en), .cfg_early_sel(cfg_early_sel),
    .ack_val(ack_val), .ack_unlock(ack_unlock), .ack_rcvd(ack_rcvd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  // Reference model state
  int     m_sq, m_cnt, m_sh, m_data, m_flag, m_ackrx, m_ha, m_hb, m_drv;
  int     m_unlock, m_ackv, m_wait, m_early;
  bit     started = 0;
  int     n_chk = 0, n_fail = 0;
  string  phase = "R13 reset";

  always @(posedge clk) begin : ref_model
    int rise, fall, rd, rel, set, nd;
    started = 1;
    if (!rst_n) begin
      m_sq = 1; m_cnt = 0; m_sh = 0; m_data = 0; m_flag = 0; m_ackrx = 0;
      m_ha = 0; m_hb = 0; m_drv = 0; m_unlock = 0; m_ackv = 0; m_wait = 0; m_early = 0;
    end else begin
      rise = (scl_in && m_sq == 0) ? 1 : 0;
      fall = (!scl_in && m_sq == 1) ? 1 : 0;
      m_sq = scl_in ? 1 : 0;
      rd   = (rx_ready && m_flag == 1) ? 1 : 0;
      rel  = (cfg_wr && m_unlock == 1) ? 1 : 0;
      set  = 0;
      nd   = m_data;
      if (start_pulse) begin
        m_cnt = 0; m_drv = 0; m_ha = 0; m_hb = 0;
      end else begin
        if (rise == 1) begin
          if (m_cnt < 8) begin
            m_sh = ((m_sh << 1) | int'(sda_in)) & 255;
            if (m_cnt == 7 && rx_mode && m_early == 1) begin set = 1; nd = m_sh; end
          end else if (m_cnt == 8) begin
            m_ackrx = int'(sda_in);
            if (rx_mode && m_early == 0) begin set = 1; nd = m_sh; end
          end
          if (m_cnt < 9) m_cnt++;
        end
        if (fall == 1) begin
          if (m_cnt == 8) begin
            m_drv = rx_mode ? 1 : 0;
            if (rx_mode && m_early == 1) m_ha = 1;
          end else if (m_cnt == 9) begin
            m_drv = 0; m_cnt = 0;
            if (rx_mode && m_wait == 1 && m_flag == 1 && rd == 0) m_hb = 1;
          end
        end
        if (rel == 1) m_ha = 0;
        if (rd == 1)  m_hb = 0;
      end
      if (set == 1) begin m_flag = 1; m_data = nd; end
      else if (rd == 1) m_flag = 0;
      if (cfg_wr) begin
        if (m_unlock == 1) m_ackv = int'(cfg_ack_val);
        m_unlock = int'(cfg_ack_unlock);
        m_wait   = int'(cfg_wait_en);
        m_early  = int'(cfg_early_sel);
      end
    end
  end

  task automatic cmp(string field, logic [7:0] got, int expv);
    n_chk++;
    if (got !== 8'(expv)) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, field, got, expv);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("rx_valid(R2/R3)", {7'b0, rx_valid}, m_flag);
      cmp("rx_data(R1)", rx_data, m_data);
      cmp("scl_pull(R4/R5/R6)", {7'b0, scl_pull}, (m_ha | m_hb));
      cmp("sda_pull(R8)", {7'b0, sda_pull}, (m_drv == 1 && m_ackv == 0) ? 1 : 0);
      cmp("ack_rcvd(R9)", {7'b0, ack_rcvd}, m_ackrx);
      cmp("ack_val(R7)", {7'b0, ack_val}, m_ackv);
      cmp("ack_unlock(R7)", {7'b0, ack_unlock}, m_unlock);
    end
  end

  // Bench-side master and software agent; single driver of all DUT inputs.
  logic m_scl = 1'b1, m_sda = 1'b1;
  bit   auto_ack = 0, auto_read = 1;
  int   rd_delay = 3, ha_cnt = 0, rd_cnt = 0;
  logic b_ack = 0, b_wait = 0, b_early = 0;

  task automatic step();
    @(negedge clk);
    cfg_wr = 1'b0; rx_ready = 1'b0; start_pulse = 1'b0;
    if (auto_ack) begin
      ha_cnt = (m_ha == 1) ? ha_cnt + 1 : 0;
      if (ha_cnt == 4) begin
        cfg_wr = 1'b1; cfg_ack_val = b_ack; cfg_ack_unlock = 1'b1;
        cfg_wait_en = b_wait; cfg_early_sel = b_early;
      end
    end
    if (auto_read) begin
      rd_cnt = (m_flag == 1) ? rd_cnt + 1 : 0;
      if (rd_cnt == rd_delay) rx_ready = 1'b1;
    end
    scl_in = m_scl & ~scl_pull;
    sda_in = m_sda & ~sda_pull;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg_write(logic a, logic u, logic w, logic e);
    step();
    cfg_wr = 1'b1; cfg_ack_val = a; cfg_ack_unlock = u; cfg_wait_en = w; cfg_early_sel = e;
    b_ack = a; b_wait = w; b_early = e;
    step();
  endtask

  task automatic send_bits(logic [7:0] d, logic ninth, int nbits);
    for (int i = 0; i < nbits; i++) begin
      m_sda = (i < 8) ? d[7-i] : ninth;
      steps(2);
      m_scl = 1'b1;
      for (int g = 0; g < 300 && !scl_in; g++) step();
      steps(3);
      m_scl = 1'b0;
      steps(2);
    end
    m_sda = 1'b1;
  endtask

  initial begin
    steps(4);
    rst_n = 1'b1;
    step();
    start_pulse = 1'b1;
    step();

    phase = "R7 write protect";
    cfg_write(1, 1, 0, 0);
    cfg_write(1, 1, 0, 0);
    cfg_write(0, 0, 0, 0);
    cfg_write(1, 0, 0, 0);
    cfg_write(1, 1, 0, 0);
    cfg_write(0, 1, 0, 0);

    phase = "R1 R2 R8 late flag with ACK";
    send_bits(8'hA5, 1'b1, 9);
    send_bits(8'h5A, 1'b1, 9);

    phase = "R11 back-pressure";
    auto_read = 0;
    send_bits(8'hC3, 1'b1, 9);
    steps(20);
    rx_ready = 1'b1;
    steps(3);
    auto_read = 1;

    phase = "R8 R9 NACK";
    cfg_write(1, 1, 0, 0);
    send_bits(8'h0F, 1'b1, 9);

    phase = "R3 R4 early flag released by ack write";
    auto_ack = 1;
    cfg_write(0, 1, 0, 1);
    send_bits(8'h81, 1'b1, 9);
    send_bits(8'h7E, 1'b1, 9);
    auto_ack = 0;

    phase = "R4 locked write keeps hold";
    cfg_write(0, 0, 0, 1);
    send_bits(8'h96, 1'b1, 8);
    steps(10);
    cfg_write(1, 0, 0, 1);
    steps(10);

    phase = "R12 start releases hold";
    step();
    start_pulse = 1'b1;
    steps(5);
    cfg_write(0, 1, 0, 0);

    phase = "R5 wait hold until read";
    cfg_write(0, 1, 1, 0);
    rd_delay = 8;
    send_bits(8'h3C, 1'b1, 9);
    send_bits(8'h99, 1'b1, 9);
    steps(12);

    phase = "R6 no wait hold";
    cfg_write(0, 1, 0, 0);
    send_bits(8'h12, 1'b1, 9);
    send_bits(8'h34, 1'b1, 9);
    steps(12);
    rd_delay = 3;

    phase = "R10 transmit mode ignores modes";
    rx_mode = 1'b0;
    cfg_write(0, 1, 1, 1);
    send_bits(8'h55, 1'b0, 9);
    send_bits(8'hAA, 1'b1, 9);
    steps(5);
    rx_mode = 1'b1;
    cfg_write(0, 1, 0, 0);
    steps(5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog in %s: actual hung expected completion", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail + 1);
    $finish;
  end
endmodule